// File: doc/BRIEF.md
# Sound Generator Register Port

This block is the processor-facing side of a three-channel programmable sound generator. It holds sixteen byte-wide registers that software reaches indirectly. A write to the select port picks a register. Later accesses to the data port then store into that register or read it back. The contents of all registers are driven out in parallel to the tone, noise, envelope and I/O logic. A one-cycle write pulse per register lets that logic latch only the register that changed.

The block decodes two address bits. Bit 1 picks the target: the select port when it is 0, the data port when it is 1. Bit 0 picks a shadow alias of the same target. A shadow write counts only for a byte-sized access. The select latch keeps all eight bits that are written to it. Any selection of 16 or more disables the data port. Some registers store fewer than eight bits, but a read taken right after a data write, with no new selection in between, returns the full byte that was written.

Top module: `sndRegPort`

## Requirements
- R1: After reset, `rdData` is 0x00, `regWe` is all zero, and every register reads 0x00 on `regFile`, except register 14, which reads 0xFF.
- R2: A write with `offset[1]`=0 loads the select latch, and a write with `offset[1]`=1 stores into the selected register. At offset 0 or 2 the write takes effect whatever the value of `byteAcc`.
- R3: A write at shadow offset 1 or 3 takes effect only when `byteAcc`=1. With `byteAcc`=0 it changes neither the selection nor any register, and it raises no `regWe` bit.
- R4: The select latch stores all 8 bits of `wrData`. While its value is 16 or more, data-port writes change no register and raise no pulse, and a read at offset 0 returns 0xFF.
- R5: A read at offset 1, 2 or 3 returns 0xFF, whatever the selection.
- R6: Registers 1, 3, 5 and 13 store only bits 3:0 of a written value, and their upper bits read 0.
- R7: Registers 6, 8, 9 and 10 store only bits 4:0 of a written value. All other registers store all 8 bits.
- R8: A read at offset 0 that follows a data write, with no new selection in between, returns the unmasked byte that was written. After a new selection, the read returns the stored, masked value.
- R9: A data write that takes effect raises `regWe[n]` for the selected register n for exactly the following cycle. In that same cycle `regFile` shows the new value. At most one bit of `regWe` is high at any time.
- R10: `rdData` is registered. It takes its new value on the clock edge that samples `cs` and `rdStb`, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rdStb | input | 1 | Read strobe, sampled with cs |
| wrStb | input | 1 | Write strobe, sampled with cs |
| offset | input | 2 | Byte offset: bit 1 picks the target, bit 0 picks the shadow alias |
| byteAcc | input | 1 | 1 when the access is byte-sized |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| regFile | output | 128 | All registers, register n at bits 8n+7:8n |
| regWe | output | 16 | One-cycle update pulse per register |

## Verification
All results are due one cycle after the clock edge that samples the access:
- The read byte appears on `rdData`.
- The stored value appears on `regFile`.
- The update pulse appears on `regWe`.

The driver changes inputs on the falling edge and holds each access for exactly one rising edge. It checks `regFile` and `regWe` on the next falling edge. For reads, the driver pushes the expected byte into a queue. The monitor flags every rising edge that sampled a read and pops the queue on the following falling edge. This keeps each comparison on the cycle in which the result is due.

// File: rtl/sndRegPkg.sv
package sndRegPkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic selWr;   // load select latch
    logic dataWr;  // store into selected register
    logic rdReg;   // read register data (offset 0)
    logic rdVoid;  // read of an offset that returns all ones
  } ctlStb_t;

  // bits kept when a value is stored into register idx
  function automatic logic [DATA_W-1:0] keepMask(input int idx);
    case (idx)
      1, 3, 5, 13:   keepMask = 8'h0F;
      6, 8, 9, 10:   keepMask = 8'h1F;
      default:       keepMask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/sndRegCtl.sv
module sndRegCtl
  import sndRegPkg::*;
(
  input  logic       cs,
  input  logic       rdStb,
  input  logic       wrStb,
  input  logic [1:0] offset,
  input  logic       byteAcc,
  output ctlStb_t    stb
);
  logic wrOk;
  logic rdAny;

  // shadow aliases (bit 0 set) are honoured only for byte accesses
  assign wrOk  = cs && wrStb && (!offset[0] || byteAcc);
  assign rdAny = cs && rdStb;

  always_comb begin
    stb        = '0;
    stb.selWr  = wrOk && !offset[1];
    stb.dataWr = wrOk && offset[1];
    stb.rdReg  = rdAny && (offset == 2'b00);
    stb.rdVoid = rdAny && (offset != 2'b00);
  end
endmodule

// File: rtl/sndRegDp.sv
module sndRegDp
  import sndRegPkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int PORTA_IDX = 14,
  parameter logic [DATA_W-1:0] PORTA_RST = 8'hFF
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStb_t                    stb,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_REGS*DATA_W-1:0] regFile,
  output logic [NUM_REGS-1:0]        regWe
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam logic [DATA_W-1:0] LIMIT = DATA_W'(NUM_REGS);

  logic [DATA_W-1:0] selLatch;
  logic [DATA_W-1:0] rdLatch;
  logic [DATA_W-1:0] regArr [NUM_REGS];
  logic              selValid;
  logic              newSelValid;
  logic [IDX_W-1:0]  selIdx;
  logic [IDX_W-1:0]  newIdx;

  assign selValid    = selLatch < LIMIT;
  assign newSelValid = wrData < LIMIT;
  assign selIdx      = selLatch[IDX_W-1:0];
  assign newIdx      = wrData[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selLatch <= '0;
      rdLatch  <= '0;
    end else begin
      if (stb.selWr) begin
        selLatch <= wrData;
        if (newSelValid) rdLatch <= regArr[newIdx];
      end else if (stb.dataWr && selValid) begin
        rdLatch <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdData <= '0;
    else if (stb.rdReg)   rdData <= selValid ? rdLatch : ALL_ONES;
    else if (stb.rdVoid)  rdData <= ALL_ONES;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    localparam logic [DATA_W-1:0] RST_VAL  = (g == PORTA_IDX) ? PORTA_RST : '0;
    localparam logic [DATA_W-1:0] KEEP     = keepMask(g);
    localparam logic [IDX_W-1:0]  MY_IDX   = IDX_W'(g);
    logic [DATA_W-1:0] q;
    logic              hit;
    logic              pulse;

    assign hit = stb.dataWr && selValid && (selIdx == MY_IDX);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        q     <= RST_VAL;
        pulse <= 1'b0;
      end else begin
        pulse <= hit;
        if (hit) q <= wrData & KEEP;
      end
    end

    assign regArr[g]                   = q;
    assign regFile[g*DATA_W +: DATA_W] = q;
    assign regWe[g]                    = pulse;
  end
endmodule

// File: rtl/sndRegPort.sv
module sndRegPort
  import sndRegPkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cs,
  input  logic                       rdStb,
  input  logic                       wrStb,
  input  logic [1:0]                 offset,
  input  logic                       byteAcc,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_REGS*DATA_W-1:0] regFile,
  output logic [NUM_REGS-1:0]        regWe
);
  ctlStb_t stb;

  sndRegCtl ctl_i (
    .cs(cs), .rdStb(rdStb), .wrStb(wrStb),
    .offset(offset), .byteAcc(byteAcc), .stb(stb)
  );

  sndRegDp #(.NUM_REGS(NUM_REGS)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .rdData(rdData), .regFile(regFile), .regWe(regWe)
  );
endmodule

// File: rtl/sndRegChk.sv
module sndRegChk #(
  parameter int NUM_REGS = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  cs,
  input logic                  rdStb,
  input logic                  wrStb,
  input logic [1:0]            offset,
  input logic                  byteAcc,
  input logic [7:0]            wrData,
  input logic [7:0]            rdData,
  input logic [NUM_REGS*8-1:0] regFile,
  input logic [NUM_REGS-1:0]   regWe
);
  // R9
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regWe));

  // R9
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cs && wrStb && offset[1]) |=> (regWe == '0));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cs && rdStb) |=> $stable(rdData));

  // R5
  rd_void_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cs && rdStb && offset != 2'b00) |=> (rdData == 8'hFF));

  // R3
  shadow_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cs && wrStb && offset == 2'b11 && !byteAcc) |=> ((regWe == '0) && $stable(regFile)));

  // R2
  sel_nopulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cs && wrStb && !offset[1]) |=> (regWe == '0));
endmodule

bind sndRegPort sndRegChk #(.NUM_REGS(NUM_REGS)) chk_i (.*);

// File: tb/sndRegPort_tb_top.sv
`timescale 1ns/1ps
module sndRegPort_tb_top;
  localparam int CLK_NS = 8;
  localparam int NREG = 16;

  logic            clk = 0;
  logic            rstN = 0;
  logic            cs = 0, rdStb = 0, wrStb = 0, byteAcc = 0;
  logic [1:0]      offset = 0;
  logic [7:0]      wrData = 0;
  logic [7:0]      rdData;
  logic [NREG*8-1:0] regFile;
  logic [NREG-1:0] regWe;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       rdSeen = 0;
  bit         done = 0;

  always #(CLK_NS/2) clk = ~clk;

  sndRegPort dut_i (
    .clk(clk), .rstN(rstN), .cs(cs), .rdStb(rdStb), .wrStb(wrStb),
    .offset(offset), .byteAcc(byteAcc), .wrData(wrData),
    .rdData(rdData), .regFile(regFile), .regWe(regWe)
  );

  function automatic logic [7:0] getReg(input int i);
    return regFile[i*8 +: 8];
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one access held over exactly one rising edge
  task automatic wr(input logic [1:0] off, input logic [7:0] d, input logic b);
    @(negedge clk);
    cs = 1; wrStb = 1; offset = off; wrData = d; byteAcc = b;
    @(negedge clk);
    cs = 0; wrStb = 0; byteAcc = 0;
  endtask

  task automatic rd(input logic [1:0] off, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cs = 1; rdStb = 1; offset = off; byteAcc = 1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    cs = 0; rdStb = 0; byteAcc = 0;
  endtask

  // monitor: a read sampled on a rising edge is compared on the next falling edge
  always @(posedge clk) rdSeen <= cs && rdStb && rstN;

  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected read result actual=%0h expected=none", rdData);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, {120'b0, rdData}, {120'b0, e});
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NREG*8-1:0] rstExp;
    logic [127:0]      snap;
    rstExp = '0;
    rstExp[14*8 +: 8] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 regFile", regFile, rstExp);
    chk("R1 rdData", {120'b0, rdData}, 128'h0);
    chk("R1 regWe", {112'b0, regWe}, 128'h0);

    // select 3, write 0x10: masked to 0 but read back unmasked
    wr(2'b00, 8'd3, 1'b0);
    chk("R2 select write no pulse", {112'b0, regWe}, 128'h0);
    wr(2'b10, 8'h10, 1'b0);
    chk("R9 pulse reg3", {112'b0, regWe}, 128'h8);
    chk("R6 reg3 masked", {120'b0, getReg(3)}, 128'h0);
    @(negedge clk);
    chk("R9 pulse one cycle", {112'b0, regWe}, 128'h0);
    rd(2'b00, 8'h10, "R8 unmasked readback");
    wr(2'b00, 8'd3, 1'b1);
    rd(2'b00, 8'h00, "R8 masked after reselect");

    // shadow select and shadow data with byte access
    wr(2'b01, 8'd8, 1'b1);
    wr(2'b11, 8'hFF, 1'b1);
    chk("R3 shadow byte write pulse", {112'b0, regWe}, 128'h100);
    chk("R7 reg8 masked", {120'b0, getReg(8)}, 128'h1F);
    rd(2'b00, 8'hFF, "R8 reg8 unmasked");
    rd(2'b10, 8'hFF, "R5 offset2");
    rd(2'b01, 8'hFF, "R5 offset1");
    rd(2'b11, 8'hFF, "R5 offset3");

    wr(2'b00, 8'd6, 1'b1);  wr(2'b10, 8'hE7, 1'b1);
    chk("R7 reg6 masked", {120'b0, getReg(6)}, 128'h07);
    wr(2'b00, 8'd13, 1'b1); wr(2'b10, 8'hAB, 1'b1);
    chk("R6 reg13 masked", {120'b0, getReg(13)}, 128'h0B);
    wr(2'b00, 8'd0, 1'b1);  wr(2'b10, 8'hAB, 1'b1);
    chk("R7 reg0 full", {120'b0, getReg(0)}, 128'hAB);
    wr(2'b00, 8'd14, 1'b0); wr(2'b10, 8'h5A, 1'b0);
    chk("R2 word write to data port", {120'b0, getReg(14)}, 128'h5A);

    // word-sized shadow select is dropped: selection stays 14
    wr(2'b01, 8'd0, 1'b0);
    wr(2'b10, 8'h33, 1'b1);
    chk("R3 shadow select dropped reg14", {120'b0, getReg(14)}, 128'h33);
    chk("R3 shadow select dropped reg0", {120'b0, getReg(0)}, 128'hAB);
    snap = regFile;
    wr(2'b11, 8'h77, 1'b0);
    chk("R3 shadow data dropped pulse", {112'b0, regWe}, 128'h0);
    chk("R3 shadow data dropped regs", regFile, snap);
    rd(2'b00, 8'h33, "R3 readback unchanged");

    // out-of-range selections
    wr(2'b00, 8'h20, 1'b1);
    snap = regFile;
    wr(2'b10, 8'h44, 1'b1);
    chk("R4 no pulse sel 0x20", {112'b0, regWe}, 128'h0);
    chk("R4 regs unchanged sel 0x20", regFile, snap);
    rd(2'b00, 8'hFF, "R4 read sel 0x20");
    wr(2'b00, 8'h10, 1'b1);
    rd(2'b00, 8'hFF, "R4 read sel 0x10");
    wr(2'b00, 8'h0F, 1'b1);
    rd(2'b00, 8'h00, "R4 sel 15 valid");

    // rdData holds between reads
    wr(2'b00, 8'd0, 1'b1);
    repeat (3) @(negedge clk);
    chk("R10 rdData held", {120'b0, rdData}, 128'h00);
    rd(2'b00, 8'hAB, "R10 new read");
    repeat (3) @(negedge clk);
    chk("R10 rdData held after read", {120'b0, rdData}, 128'hAB);

    repeat (2) @(negedge clk);
    chk("R10 all reads returned", expQ.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule